// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-monitoring counter. Every cycle it sees a bus of occurrence bits, arranged as groups of eight sub-events. A configurable event code picks one group, and a unit mask then picks which of that group's sub-events take part. The number of selected sub-events that fired in the cycle is the raw per-cycle count.

Before the raw count reaches the 48-bit accumulator, it passes through a set of qualifiers. A threshold compare can turn it into a single-cycle condition, and that compare can be inverted. An edge detector can reduce a condition to one count per busy period. A privilege filter can restrict counting to ring 0 or to rings 1 to 3.

Software programs a control word, reads or loads the counter, and reads or clears a sticky overflow flag through a small register port. An overflow can raise a level interrupt.

Top module: `qual_event_counter`

## Requirements
- R1: Group k of the event bus occupies bits [8k+7:8k]. The event code (control bits [7:0]) selects group k when it equals k, and any code not below NCODES selects nothing. The raw per-cycle count is the number of set bits in the selected group ANDed with the unit mask (control bits [15:8]).
- R2: With the threshold field (control bits [19:16]) at zero and edge mode off, the counter adds the raw count each cycle. The invert bit (control bit 20) then has no effect.
- R3: With a nonzero threshold and invert clear, the counter adds one in a cycle whose raw count is greater than or equal to the threshold, and adds nothing otherwise.
- R4: With a nonzero threshold and invert set, the counter adds one in a cycle whose raw count is below the threshold.
- R5: With edge mode (control bit 21) set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. With a zero threshold, the qualified condition is a nonzero raw count.
- R6: The privilege input is cpl. When kernel mode (control bit 22) is set, counting is allowed at cpl 0. When user mode (control bit 23) is set, counting is allowed at cpl 1 to 3. When both bits are clear, counting is allowed at every level.
- R7: The counter changes only while the enable bit (control bit 25) is set. Disabling also clears the edge history, so a condition that is already true when counting is re-enabled is counted once.
- R8: Register address 0 is the control word, address 1 is the counter and address 2 is status, with bit 0 the overflow flag. Reads are combinational. A counter write in the same cycle as an increment wins.
- R9: When an increment wraps the counter past all ones, the overflow flag is set. It stays set until software writes 1 to status bit 0. The irq output equals the overflow flag while interrupt enable (control bit 24) is set.
- R10: A threshold of 1 with edge mode set counts busy periods rather than busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_bus | input | NCODES*8 | Per-cycle occurrence bits, eight per event group |
| cpl | input | 2 | Current privilege level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address for read and write |
| cfg_wdata | input | CW | Register write data |
| cfg_rdata | output | CW | Register read data |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The bench drives raw counts just below, at and above the threshold. A compare with an off-by-one or a reversed invert would therefore miscount these segments.

It holds a condition across several busy periods and across a disable and re-enable. A detector that counts levels, or that keeps stale history, would give a total that is too high or too low.

It loads the counter while increments are still arriving and checks that the written value survives, then drives the counter over the wrap point. A wrong carry, a flag that fails to stick, or an interrupt that ignores its enable shows up on the status readback and on irq.

// File: rtl/qual_event_counter.sv
module qual_event_counter #(
  parameter int NCODES = 4,
  parameter int CW     = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCODES*8-1:0] ev_bus,
  input  logic [1:0]        cpl,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CW-1:0]     cfg_wdata,
  output logic [CW-1:0]     cfg_rdata,
  output logic              irq
);
  localparam int CTLW = 26;
  localparam int NW   = 4;

  logic [CTLW-1:0] ctl;
  logic [CW-1:0]   ctr;
  logic            ovf, prev;

  wire [7:0]    code  = ctl[7:0];
  wire [7:0]    umask = ctl[15:8];
  wire [NW-1:0] thr   = ctl[19:16];
  wire          inv   = ctl[20];
  wire          edg   = ctl[21];
  wire          os_m  = ctl[22];
  wire          usr_m = ctl[23];
  wire          ie    = ctl[24];
  wire          en    = ctl[25];

  logic [7:0]    grp;
  logic [NW-1:0] n;
  always_comb begin
    grp = '0;
    for (int k = 0; k < NCODES; k++)
      if (code == 8'(k)) grp = ev_bus[8*k +: 8];
    n = '0;
    for (int b = 0; b < 8; b++) n = n + NW'(grp[b] & umask[b]);
  end

  wire thr_on  = (thr != '0);
  wire pass    = thr_on ? ((n >= thr) ^ inv) : (n != '0);
  wire priv_ok = (!os_m && !usr_m) || (os_m && cpl == 2'd0) || (usr_m && cpl != 2'd0);
  wire qual    = priv_ok && pass;

  logic [NW-1:0] step;
  always_comb begin
    if (edg)         step = NW'(qual && !prev);
    else if (thr_on) step = NW'(qual);
    else             step = priv_ok ? n : '0;
  end

  wire [CW:0] sum    = {1'b0, ctr} + {{(CW+1-NW){1'b0}}, step};
  wire        wr_ctl = cfg_we && cfg_addr == 2'd0;
  wire        wr_ctr = cfg_we && cfg_addr == 2'd1;
  wire        wr_st  = cfg_we && cfg_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      ctr  <= '0;
      ovf  <= 1'b0;
      prev <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= cfg_wdata[CTLW-1:0];
      if (wr_ctr)  ctr <= cfg_wdata;
      else if (en) ctr <= sum[CW-1:0];
      prev <= en ? qual : 1'b0;
      if (en && !wr_ctr && sum[CW]) ovf <= 1'b1;
      else if (wr_st && cfg_wdata[0]) ovf <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {{(CW-CTLW){1'b0}}, ctl};
      2'd1:    cfg_rdata = ctr;
      2'd2:    cfg_rdata = {{(CW-1){1'b0}}, ovf};
      default: cfg_rdata = '0;
    endcase
  end

  assign irq = ovf && ie;

  p_wr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctr |=> ctr == $past(cfg_wdata));
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_ctr) |=> $stable(ctr));
  p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edg && !wr_ctr) |=> (ctr - $past(ctr)) <= CW'(1));
  p_thr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && thr_on && !wr_ctr) |=> (ctr - $past(ctr)) <= CW'(1));
  p_priv_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (os_m && !usr_m && cpl != 2'd0 && !wr_ctr) |=> $stable(ctr));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_st && cfg_wdata[0])) |=> ovf);
endmodule

// File: tb/qual_event_counter_tb.sv
module qual_event_counter_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ev_bus = '0;
  logic [1:0]  cpl = 2'd0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [47:0] cfg_wdata = '0;
  logic [47:0] cfg_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  qual_event_counter u_dut (.clk(clk), .rst_n(rst_n), .ev_bus(ev_bus), .cpl(cpl),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq));

  always #2 clk = ~clk;

  function automatic logic [47:0] mk(int code, int um, int th, bit iv, bit ed,
                                     bit os, bit us, bit ie, bit en);
    return 48'(code & 255) | (48'(um & 255) << 8) | (48'(th & 15) << 16) |
           (48'(iv) << 20) | (48'(ed) << 21) | (48'(os) << 22) |
           (48'(us) << 23) | (48'(ie) << 24) | (48'(en) << 25);
  endfunction

  task automatic chk(string req, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [47:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [47:0] v);
    cfg_addr = a; #1; v = cfg_rdata;
  endtask

  task automatic run(int n, logic [31:0] ev);
    ev_bus = ev;
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(logic [47:0] c, logic [47:0] start);
    ev_bus = '0;
    wr(2'd0, c & ~(48'd1 << 25));
    wr(2'd1, start);
    wr(2'd0, c);
  endtask

  task automatic t_reset;
    logic [47:0] v;
    rd(2'd0, v); chk("R8 reset ctl", v, 0);
    rd(2'd1, v); chk("R8 reset ctr", v, 0);
    rd(2'd2, v); chk("R9 reset status", v, 0);
    chk("R9 reset irq", 48'(irq), 0);
  endtask

  task automatic t_select;
    logic [47:0] v;
    setup(mk(2, 8'h0F, 0, 0, 0, 0, 0, 0, 1), 0);
    run(5, 32'h003C_0000); rd(2'd1, v); chk("R1 R2 raw sum", v, 10);
    setup(mk(2, 8'h0F, 0, 1, 0, 0, 0, 0, 1), 0);
    run(5, 32'h003C_0000); rd(2'd1, v); chk("R2 invert ignored", v, 10);
    setup(mk(9, 8'hFF, 0, 0, 0, 0, 0, 0, 1), 0);
    run(4, 32'hFFFF_FFFF); rd(2'd1, v); chk("R1 code out of range", v, 0);
    setup(mk(1, 8'h00, 0, 0, 0, 0, 0, 0, 1), 0);
    run(4, 32'hFFFF_FFFF); rd(2'd1, v); chk("R1 empty unit mask", v, 0);
  endtask

  task automatic t_thresh;
    logic [47:0] v;
    setup(mk(1, 8'hFF, 3, 0, 0, 0, 0, 0, 1), 0);
    run(4, 32'h0000_0700); run(3, 32'h0000_0300); run(2, 32'h0000_FF00);
    rd(2'd1, v); chk("R3 threshold ge", v, 6);
    setup(mk(1, 8'hFF, 3, 1, 0, 0, 0, 0, 1), 0);
    run(4, 32'h0000_0700); run(3, 32'h0000_0300); run(2, 32'h0000_FF00);
    rd(2'd1, v); chk("R4 inverted threshold", v, 3);
  endtask

  task automatic t_edge;
    logic [47:0] v;
    setup(mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 1), 0);
    run(3, 32'h1); run(2, 32'h0); run(4, 32'h1); run(1, 32'h0); run(1, 32'h1);
    rd(2'd1, v); chk("R10 busy periods", v, 3);
    setup(mk(0, 8'h03, 0, 0, 1, 0, 0, 0, 1), 0);
    run(2, 32'h3); run(1, 32'h0); run(3, 32'h1);
    rd(2'd1, v); chk("R5 edge on nonzero count", v, 2);
  endtask

  task automatic t_priv;
    logic [47:0] v;
    setup(mk(0, 8'h03, 0, 0, 0, 1, 0, 0, 1), 0);
    cpl = 2'd0; run(3, 32'h3); cpl = 2'd2; run(3, 32'h3);
    rd(2'd1, v); chk("R6 kernel only", v, 6);
    setup(mk(0, 8'h03, 0, 0, 0, 0, 1, 0, 1), 0);
    cpl = 2'd0; run(3, 32'h3); cpl = 2'd3; run(2, 32'h3);
    rd(2'd1, v); chk("R6 user only", v, 4);
    setup(mk(0, 8'h03, 0, 0, 0, 0, 0, 0, 1), 0);
    cpl = 2'd1; run(2, 32'h3); cpl = 2'd0; run(2, 32'h3);
    rd(2'd1, v); chk("R6 no filter bits", v, 8);
    cpl = 2'd0;
  endtask

  task automatic t_enable;
    logic [47:0] v;
    setup(mk(0, 8'h03, 0, 0, 0, 0, 0, 0, 0), 48'h55);
    run(5, 32'h3); rd(2'd1, v); chk("R7 disabled holds", v, 48'h55);
    setup(mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 1), 0);
    run(3, 32'h1);
    wr(2'd0, mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 0));
    run(2, 32'h1);
    wr(2'd0, mk(0, 8'h01, 1, 0, 1, 0, 0, 0, 1));
    run(2, 32'h1);
    rd(2'd1, v); chk("R7 edge history cleared", v, 2);
  endtask

  task automatic t_write;
    logic [47:0] v;
    setup(mk(0, 8'h03, 0, 0, 0, 0, 0, 0, 1), 0);
    ev_bus = 32'h3;
    wr(2'd1, 48'd100);
    rd(2'd1, v); chk("R8 write beats increment", v, 100);
    run(3, 32'h3); rd(2'd1, v); chk("R8 counting after write", v, 106);
  endtask

  task automatic t_ovf;
    logic [47:0] v;
    setup(mk(0, 8'h03, 0, 0, 0, 0, 0, 0, 1), 48'hFFFF_FFFF_FFFD);
    run(1, 32'h3); rd(2'd1, v); chk("R9 reach all ones", v, 48'hFFFF_FFFF_FFFF);
    rd(2'd2, v); chk("R9 no flag before wrap", v, 0);
    run(1, 32'h3); rd(2'd1, v); chk("R9 wrapped value", v, 1);
    rd(2'd2, v); chk("R9 flag set", v, 1);
    chk("R9 irq masked", 48'(irq), 0);
    ev_bus = '0;
    wr(2'd0, mk(0, 8'h03, 0, 0, 0, 0, 0, 1, 1));
    chk("R9 irq when enabled", 48'(irq), 1);
    run(3, 32'h0); chk("R9 irq sticky", 48'(irq), 1);
    wr(2'd2, 48'd0); rd(2'd2, v); chk("R9 write zero keeps flag", v, 1);
    wr(2'd2, 48'd1); rd(2'd2, v); chk("R9 flag cleared", v, 0);
    chk("R9 irq cleared", 48'(irq), 0);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_thresh();
    t_edge();
    t_priv();
    t_enable();
    t_write();
    t_ovf();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule